// File: doc/BRIEF.md
# Compound-Opcode Execution Unit

This block performs the undocumented two-step instructions of an 8-bit accumulator processor. The surrounding core fetches the opcode and its operand byte, which may be a memory byte or an immediate. It presents them with the current accumulator, index register and the four arithmetic flags, then pulses `start`. The unit returns the byte to store back to memory, the new accumulator and index values, the new flags, and a sticky halt signal. Address generation, bus timing and decimal arithmetic belong to the core, not to this unit.

A read-modify-write opcode runs in two steps, always in the same order. The operand is first shifted or rotated, and that byte is offered for write-back. The modified byte, together with the carry its shift produced, then feeds an accumulator operation. Immediate-only opcodes skip the first step.

The controller has four states:
- **IDLE** waits for `start`. Accepting an opcode moves to MODIFY for a read-modify-write family, to HALT for a halt opcode, and to COMBINE for anything else.
- **MODIFY** registers the shifted byte, pulses the write strobe and always moves on to COMBINE.
- **COMBINE** updates the registers and flags, pulses `done` and returns to IDLE.
- **HALT** has no exit. Only reset leaves it.

Top module: `cmpd_exec_unit`

## Requirements
- R1: Opcodes 03,07,0F,13,17,1B,1F (hex) shift the operand left, with a zero entering bit 0. The old bit 7 becomes C, the shifted byte is written back, and A becomes A OR that byte.
- R2: Opcodes 23,27,2F,33,37,3B,3F rotate the operand left, with the incoming C entering bit 0. The old bit 7 becomes C, the byte is written back, and A becomes A AND that byte.
- R3: Opcodes 43,47,4F,53,57,5B,5F shift the operand right, with a zero entering bit 7. The old bit 0 becomes C, the byte is written back, and A becomes A XOR that byte.
- R4: Opcodes 63,67,6F,73,77,7B,7F rotate the operand right, with the incoming C entering bit 7, and write the byte back. A then becomes A + byte + (old operand bit 0) in binary. C takes the carry out of bit 7. V is set when A and the byte have the same sign and the sum's sign differs.
- R5: Opcodes 0B and 2B set A to A AND operand, then copy bit 7 of the new A into C.
- R6: Opcode 4B forms A AND operand, puts bit 0 of that value into C, and sets A to that value shifted right with a zero in bit 7.
- R7: Opcode CB sets X to (A AND X) minus the operand, modulo 256, with no borrow-in and A unchanged. C is 1 when no borrow occurs and 0 when one does.
- R8: Opcodes 02,12,22,32,42,52,62,72 raise `halted` one cycle after acceptance. From then on no opcode completes and no write occurs, until reset clears `halted`.
- R9: N equals bit 7 and Z equals (value == 0) of the register written: X for opcode CB, A for every other listed opcode. V is unchanged except under R4.
- R10: The read-modify-write opcodes pulse `mem_we` for one cycle with the modified byte on `mem_wdata`, two cycles after acceptance. `done` follows on the next cycle. Immediate-only opcodes raise `done` two cycles after acceptance and never raise `mem_we`.
- R11: Any other opcode produces outputs equal to the supplied A, X and flags, raises `done` two cycles after acceptance, and never raises `mem_we`.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the presented opcode (honoured in IDLE) |
| opcode | input | 8 | Instruction byte |
| operand | input | DW | Fetched memory byte or immediate |
| a_in | input | DW | Current accumulator |
| x_in | input | DW | Current index register |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | One-cycle write-back strobe |
| mem_wdata | output | DW | Byte to write back |
| a_out | output | DW | Resulting accumulator |
| x_out | output | DW | Resulting index register |
| n_out | output | 1 | Resulting negative flag |
| v_out | output | 1 | Resulting overflow flag |
| z_out | output | 1 | Resulting zero flag |
| c_out | output | 1 | Resulting carry flag |
| halted | output | 1 | Sticky halt indication |

## Verification
The bench builds the unit with its default data width of 8. At that width every operand value can be swept against several accumulator, index and carry values for each opcode family, so every carry-out, borrow and signed-overflow corner is reached. All 256 opcodes are also issued once, which checks the decode boundary between the listed families and everything else. Each halt opcode is then tried, followed by reset.

// File: rtl/cmpd_pkg.sv
package cmpd_pkg;

    localparam int OPW = 8;

    typedef enum logic [3:0] {
        F_NONE,
        F_SLO,
        F_RLA,
        F_SRE,
        F_RRA,
        F_ANC,
        F_ASR,
        F_AXS,
        F_JAM
    } fam_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MODIFY,
        S_COMBINE,
        S_HALT
    } state_e;

    function automatic logic is_rmw(fam_e f);
        return (f == F_SLO) || (f == F_RLA) || (f == F_SRE) || (f == F_RRA);
    endfunction

endpackage

// File: rtl/cmpd_decode.sv
module cmpd_decode
    import cmpd_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output fam_e           fam
);
    always_comb begin
        fam = F_NONE;
        if (!opcode[7] && opcode[3:0] == 4'h2) begin
            fam = F_JAM;
        end else if (!opcode[7] && opcode[1:0] == 2'b11 && opcode[4:2] != 3'b010) begin
            unique case (opcode[6:5])
                2'b00: fam = F_SLO;
                2'b01: fam = F_RLA;
                2'b10: fam = F_SRE;
                2'b11: fam = F_RRA;
                default: fam = F_NONE;
            endcase
        end else if (opcode == 8'h0B || opcode == 8'h2B) begin
            fam = F_ANC;
        end else if (opcode == 8'h4B) begin
            fam = F_ASR;
        end else if (opcode == 8'hCB) begin
            fam = F_AXS;
        end
    end
endmodule

// File: rtl/cmpd_modify.sv
module cmpd_modify
    import cmpd_pkg::*;
#(
    parameter int DW = 8
) (
    input  fam_e          fam,
    input  logic [DW-1:0] opd,
    input  logic          cin,
    output logic [DW-1:0] mod,
    output logic          cout
);
    always_comb begin
        mod  = opd;
        cout = cin;
        unique case (fam)
            F_SLO: begin
                mod  = {opd[DW-2:0], 1'b0};
                cout = opd[DW-1];
            end
            F_RLA: begin
                mod  = {opd[DW-2:0], cin};
                cout = opd[DW-1];
            end
            F_SRE: begin
                mod  = {1'b0, opd[DW-1:1]};
                cout = opd[0];
            end
            F_RRA: begin
                mod  = {cin, opd[DW-1:1]};
                cout = opd[0];
            end
            default: begin
                mod  = opd;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/cmpd_combine.sv
module cmpd_combine
    import cmpd_pkg::*;
#(
    parameter int DW = 8
) (
    input  fam_e          fam,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] b,
    input  logic          mcarry,
    input  logic          n,
    input  logic          v,
    input  logic          z,
    input  logic          c,
    output logic [DW-1:0] ao,
    output logic [DW-1:0] xo,
    output logic          no,
    output logic          vo,
    output logic          zo,
    output logic          co
);
    logic [DW:0]   wide;
    logic [DW-1:0] tmp;

    always_comb begin
        ao   = a;
        xo   = x;
        no   = n;
        vo   = v;
        zo   = z;
        co   = c;
        wide = '0;
        tmp  = '0;
        unique case (fam)
            F_SLO: begin
                ao = a | b;
                co = mcarry;
            end
            F_RLA: begin
                ao = a & b;
                co = mcarry;
            end
            F_SRE: begin
                ao = a ^ b;
                co = mcarry;
            end
            F_RRA: begin
                wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, mcarry};
                ao   = wide[DW-1:0];
                co   = wide[DW];
                vo   = ~(a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ wide[DW-1]);
            end
            F_ANC: begin
                ao = a & b;
                co = ao[DW-1];
            end
            F_ASR: begin
                tmp = a & b;
                ao  = {1'b0, tmp[DW-1:1]};
                co  = tmp[0];
            end
            F_AXS: begin
                tmp  = a & x;
                wide = {1'b0, tmp} - {1'b0, b};
                xo   = wide[DW-1:0];
                co   = ~wide[DW];
            end
            default: begin
                ao = a;
            end
        endcase

        if (fam == F_AXS) begin
            no = xo[DW-1];
            zo = (xo == '0);
        end else if (fam != F_NONE && fam != F_JAM) begin
            no = ao[DW-1];
            zo = (ao == '0);
        end
    end
endmodule

// File: rtl/cmpd_exec_unit.sv
module cmpd_exec_unit
    import cmpd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  operand,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  x_in,
    input  logic           n_in,
    input  logic           v_in,
    input  logic           z_in,
    input  logic           c_in,
    output logic           done,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    output logic [DW-1:0]  a_out,
    output logic [DW-1:0]  x_out,
    output logic           n_out,
    output logic           v_out,
    output logic           z_out,
    output logic           c_out,
    output logic           halted
);
    state_e        state_q, state_d;
    fam_e          fam_dec, fam_q;
    logic [DW-1:0] op_q, a_q, x_q, m_q;
    logic          n_q, v_q, z_q, c_q, cm_q;

    logic [DW-1:0] mod_byte;
    logic          mod_carry;
    logic [DW-1:0] cmb_b, cmb_a, cmb_x;
    logic          cmb_n, cmb_v, cmb_z, cmb_c;

    cmpd_decode u_decode (
        .opcode (opcode),
        .fam    (fam_dec)
    );

    cmpd_modify #(.DW(DW)) u_modify (
        .fam  (fam_q),
        .opd  (op_q),
        .cin  (c_q),
        .mod  (mod_byte),
        .cout (mod_carry)
    );

    assign cmb_b = is_rmw(fam_q) ? m_q : op_q;

    cmpd_combine #(.DW(DW)) u_combine (
        .fam    (fam_q),
        .a      (a_q),
        .x      (x_q),
        .b      (cmb_b),
        .mcarry (cm_q),
        .n      (n_q),
        .v      (v_q),
        .z      (z_q),
        .c      (c_q),
        .ao     (cmb_a),
        .xo     (cmb_x),
        .no     (cmb_n),
        .vo     (cmb_v),
        .zo     (cmb_z),
        .co     (cmb_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (fam_dec == F_JAM)     state_d = S_HALT;
                    else if (is_rmw(fam_dec)) state_d = S_MODIFY;
                    else                      state_d = S_COMBINE;
                end
            end
            S_MODIFY:  state_d = S_COMBINE;
            S_COMBINE: state_d = S_IDLE;
            S_HALT:    state_d = S_HALT;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fam_q     <= F_NONE;
            op_q      <= '0;
            a_q       <= '0;
            x_q       <= '0;
            m_q       <= '0;
            n_q       <= 1'b0;
            v_q       <= 1'b0;
            z_q       <= 1'b0;
            c_q       <= 1'b0;
            cm_q      <= 1'b0;
            done      <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            a_out     <= '0;
            x_out     <= '0;
            n_out     <= 1'b0;
            v_out     <= 1'b0;
            z_out     <= 1'b0;
            c_out     <= 1'b0;
            halted    <= 1'b0;
        end else begin
            done   <= 1'b0;
            mem_we <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        fam_q <= fam_dec;
                        op_q  <= operand;
                        a_q   <= a_in;
                        x_q   <= x_in;
                        n_q   <= n_in;
                        v_q   <= v_in;
                        z_q   <= z_in;
                        c_q   <= c_in;
                        cm_q  <= c_in;
                        if (fam_dec == F_JAM) halted <= 1'b1;
                    end
                end
                S_MODIFY: begin
                    m_q       <= mod_byte;
                    cm_q      <= mod_carry;
                    mem_we    <= 1'b1;
                    mem_wdata <= mod_byte;
                end
                S_COMBINE: begin
                    a_out <= cmb_a;
                    x_out <= cmb_x;
                    n_out <= cmb_n;
                    v_out <= cmb_v;
                    z_out <= cmb_z;
                    c_out <= cmb_c;
                    done  <= 1'b1;
                end
                S_HALT: begin
                    halted <= 1'b1;
                end
                default: begin
                    done <= 1'b0;
                end
            endcase
        end
    end

    // R10: a write strobe is one cycle wide and is followed by completion
    a_r10_we_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (done && !mem_we));

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: halt is sticky and silences the unit
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !done && !mem_we));

    // R5: carry mirrors the accumulator sign after the AND-carry opcode
    a_r5_anc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fam_q == F_ANC) |-> (c_out == a_out[DW-1]));

    // R9: zero flag tracks the accumulator for accumulator-writing families
    a_r9_zero_tracks_a: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fam_q != F_NONE && fam_q != F_AXS) |-> (z_out == (a_out == '0)));

    // R11: unlisted opcodes hand the captured accumulator back untouched
    a_r11_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fam_q == F_NONE) |-> (a_out == a_q && x_out == x_q && c_out == c_q));

endmodule

// File: tb/test_cmpd_exec_unit.sv
module test_cmpd_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = '0, operand = '0, a_in = '0, x_in = '0;
    logic       n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
    logic       done, mem_we, n_out, v_out, z_out, c_out, halted;
    logic [7:0] mem_wdata, a_out, x_out;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpd_exec_unit #(.DW(8)) i_cmpd_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .a_in(a_in), .x_in(x_in), .n_in(n_in), .v_in(v_in), .z_in(z_in), .c_in(c_in),
        .done(done), .mem_we(mem_we), .mem_wdata(mem_wdata), .a_out(a_out), .x_out(x_out),
        .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out), .halted(halted)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rmw_low(input int i);
        case (i)
            0: return 8'h03;
            1: return 8'h07;
            2: return 8'h0F;
            3: return 8'h13;
            4: return 8'h17;
            5: return 8'h1B;
            default: return 8'h1F;
        endcase
    endfunction

    // kind: 0 = no effect, 1 = read-modify-write, 2 = immediate only
    task automatic model(input logic [7:0] opc, opd, a, x, input logic n, v, z, c,
                         output logic [7:0] ea, ex, ew, output logic en, ev, ez, ec,
                         output int kind, output string tag);
        logic [7:0] m, t;
        int sum;
        bit xw;
        ea = a; ex = x; ew = 8'h00; en = n; ev = v; ez = z; ec = c; kind = 0; tag = "R11";
        xw = 1'b0;
        if (opc inside {8'h03, 8'h07, 8'h0F, 8'h13, 8'h17, 8'h1B, 8'h1F}) begin
            m = (opd * 2) % 256; ec = opd >= 128; ea = a | m; ew = m; kind = 1; tag = "R1";
        end else if (opc inside {8'h23, 8'h27, 8'h2F, 8'h33, 8'h37, 8'h3B, 8'h3F}) begin
            m = (opd * 2 + c) % 256; ec = opd >= 128; ea = a & m; ew = m; kind = 1; tag = "R2";
        end else if (opc inside {8'h43, 8'h47, 8'h4F, 8'h53, 8'h57, 8'h5B, 8'h5F}) begin
            m = opd / 2; ec = opd % 2; ea = a ^ m; ew = m; kind = 1; tag = "R3";
        end else if (opc inside {8'h63, 8'h67, 8'h6F, 8'h73, 8'h77, 8'h7B, 8'h7F}) begin
            m = opd / 2 + (c ? 128 : 0);
            sum = int'(a) + int'(m) + int'(opd % 2);
            ea = sum % 256; ec = sum > 255;
            ev = ((a ^ ea) & (m ^ ea) & 8'h80) != 0;
            ew = m; kind = 1; tag = "R4";
        end else if (opc == 8'h0B || opc == 8'h2B) begin
            ea = a & opd; ec = ea >= 128; kind = 2; tag = "R5";
        end else if (opc == 8'h4B) begin
            t = a & opd; ea = t / 2; ec = t % 2; kind = 2; tag = "R6";
        end else if (opc == 8'hCB) begin
            t = a & x; ex = (int'(t) - int'(opd) + 256) % 256; ec = t >= opd;
            kind = 2; tag = "R7"; xw = 1'b1;
        end
        if (kind != 0) begin
            en = xw ? ex[7] : ea[7];
            ez = xw ? (ex == 0) : (ea == 0);
        end
    endtask

    task automatic do_op(input logic [7:0] opc, opd, a, x, input logic n, v, z, c);
        logic [7:0] ea, ex, ew, wd;
        logic en, ev, ez, ec;
        int kind, we_at, done_at, exp_done, exp_we;
        string tag;
        model(opc, opd, a, x, n, v, z, c, ea, ex, ew, en, ev, ez, ec, kind, tag);
        @(negedge clk);
        opcode = opc; operand = opd; a_in = a; x_in = x;
        n_in = n; v_in = v; z_in = z; c_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        we_at = 0; done_at = 0; wd = 8'h00;
        for (int k = 1; k <= 8; k++) begin
            if (mem_we) begin we_at = k; wd = mem_wdata; end
            if (done) begin done_at = k; break; end
            @(negedge clk);
        end
        exp_done = (kind == 1) ? 3 : 2;
        exp_we   = (kind == 1) ? 2 : 0;
        check(done_at == exp_done, kind == 0 ? "R11" : "R10", "done cycle", done_at, exp_done);
        check(we_at == exp_we, kind == 0 ? "R11" : "R10", "write cycle", we_at, exp_we);
        if (kind == 1) check(wd == ew, tag, "write-back byte", wd, ew);
        check({a_out, x_out, v_out, c_out} == {ea, ex, ev, ec}, tag, "A,X,V,C",
              {14'h0, a_out, x_out, v_out, c_out}, {14'h0, ea, ex, ev, ec});
        check({n_out, z_out} == {en, ez}, kind == 0 ? "R11" : "R9", "N,Z",
              {n_out, z_out}, {en, ez});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] avals [4];
        logic [7:0] hold_a;
        avals[0] = 8'h00; avals[1] = 8'hFF; avals[2] = 8'h5A; avals[3] = 8'h81;

        repeat (3) @(negedge clk);
        // R12: reset state
        check({done, mem_we, halted, n_out, v_out, z_out, c_out} == 7'b0, "R12", "flags",
              {done, mem_we, halted, n_out, v_out, z_out, c_out}, 0);
        check({mem_wdata, a_out, x_out} == 24'h0, "R12", "bytes", {mem_wdata, a_out, x_out}, 0);
        rst_n = 1'b1;

        // R1..R4 sweeps over operand, accumulator and carry
        for (int f = 0; f < 4; f++)
            for (int opv = 0; opv < 256; opv++)
                for (int ai = 0; ai < 4; ai++)
                    for (int cv = 0; cv < 2; cv++)
                        do_op(rmw_low(opv % 7) + 8'(f * 32), 8'(opv), avals[ai] ^ 8'(ai * opv),
                              8'(opv + 7), opv[7], opv[1], opv[2], cv[0]);

        // R5, R6 immediate sweeps
        for (int opv = 0; opv < 256; opv++)
            for (int ai = 0; ai < 4; ai++)
                for (int cv = 0; cv < 2; cv++) begin
                    do_op(cv[0] ? 8'h2B : 8'h0B, 8'(opv), avals[ai], 8'h33, 1'b0, cv[0], 1'b1, cv[0]);
                    do_op(8'h4B, 8'(opv), avals[ai] ^ 8'(opv * 3), 8'h44, cv[0], 1'b1, 1'b0, cv[0]);
                end

        // R7 sweep over operand, A and X
        for (int opv = 0; opv < 256; opv++)
            for (int ai = 0; ai < 4; ai++)
                for (int xi = 0; xi < 4; xi++)
                    do_op(8'hCB, 8'(opv), avals[ai], avals[xi] ^ 8'(opv + xi),
                          1'b0, opv[0], 1'b0, opv[1]);

        // R11 and decode boundary: every opcode that is not a halt
        for (int o = 0; o < 256; o++)
            if (!(o < 128 && (o % 16) == 2))
                do_op(8'(o), 8'h96, 8'hC3, 8'h5E, 1'b1, 1'b1, 1'b0, o[0]);

        // R8: each halt opcode, then reset
        for (int j = 0; j < 8; j++) begin
            do_op(8'h0B, 8'hF0, 8'hAA, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
            hold_a = a_out;
            @(negedge clk);
            opcode = 8'(j * 16 + 2); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(halted == 1'b1, "R8", "halt raised", halted, 1);
            @(negedge clk);
            opcode = 8'h07; operand = 8'h01; a_in = 8'h00; start = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                start = 1'b0;
                check(!done && !mem_we && halted, "R8", "silent while halted",
                      {done, mem_we, halted}, 3'b001);
            end
            check(a_out == hold_a, "R8", "A held while halted", a_out, hold_a);
            rst_n = 1'b0;
            @(negedge clk);
            check(halted == 1'b0, "R8", "reset clears halt", halted, 0);
            rst_n = 1'b1;
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule